// File: doc/BRIEF.md
# Multiplexed GPIO Port with Pin Assignment

An eight-bit general-purpose I/O port that sits on a simple byte-oriented register bus. Every pin can serve either the port itself, where a data latch supplies the output level and a direction register supplies the output enable, or an alternate control function whose output value and enable arrive on dedicated inputs. A per-pin assignment register picks between the two. Pin levels are synchronized and then offered both to the register read path and to the alternate function.

The assignment register takes its reset value from one external configuration line. That line is copied into every assignment bit on each clock edge while reset is held low, so the clock must run during reset. The data latch answers at two word addresses that share one storage. Locations are 16 bits wide, and only the low byte of each is implemented.

Top module: `gpio_mux_port`

## Requirements
- R1: The data latch is written through word address 0 or word address 1. Both addresses reach the same storage. The latch has no reset value.
- R2: A read of address 0 or 1 returns, for each bit, the latch bit when that pin's direction bit is 1, and the synchronized pin level when it is 0.
- R3: Direction register, at word address 2: a bit of 1 makes the pin an output and a bit of 0 makes it an input. Every bit clears to 0 on reset.
- R4: Assignment register, at word address 3: a bit of 1 drives pin_out and pin_oe for that pin from alt_out and alt_oe. A bit of 0 drives them from the data latch and the direction register.
- R5: On every clock edge while rst_n is low, every assignment bit loads the value of cfg_line.
- R6: The upper byte of every read is zero, and write data bits 15:8 are ignored. Word addresses 4 to 7 read as zero, and writes to them change nothing.
- R7: pin_in passes through two flops before it reaches alt_in or the read path. A change becomes visible after the second rising edge.
- R8: A write takes effect at the edge on which bus_wr is sampled. bus_rdata updates on the edge that samples bus_rd, keeps its value when no read is made, and clears to zero on reset.
- R9: Reads of addresses 2 and 3 return the direction and assignment registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (async for direction, sync, read data) |
| cfg_line | input | 1 | Configuration level copied into the assignment bits during reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 16 | Write data; only bits 7:0 are used |
| bus_rdata | output | 16 | Registered read data |
| pin_in | input | 8 | Raw pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| alt_out | input | 8 | Alternate function output values |
| alt_oe | input | 8 | Alternate function output enables |
| alt_in | output | 8 | Synchronized pin levels for the alternate function |

## Verification
The hardest situation to create is a data read that mixes sources: some bits must come from the latch and others from live pins, and the pin level must already have crossed the synchronizer. The stimulus sets direction bits at random and changes pin_in, then waits three cycles before any read. Because the expected word depends on the direction bits, the pin level and the latch together, each read checks the per-bit selection. A second reset, with the configuration line at the opposite level, shows that the assignment bits follow the line while the latch keeps its contents.

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
  parameter int W  = 8,
  parameter int AW = 3,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_line,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  input  logic [W-1:0]  alt_out,
  input  logic [W-1:0]  alt_oe,
  output logic [W-1:0]  alt_in
);
  localparam int PADW = DW - W;
  localparam logic [AW-1:0] A_DAT0 = AW'(0);
  localparam logic [AW-1:0] A_DAT1 = AW'(1);
  localparam logic [AW-1:0] A_DIR  = AW'(2);
  localparam logic [AW-1:0] A_ASG  = AW'(3);

  logic [W-1:0] lat_q, dir_q, asg_q, s1_q, s2_q, rd_val;

  wire wr_dat = bus_wr && (bus_addr == A_DAT0 || bus_addr == A_DAT1);
  wire wr_dir = bus_wr && (bus_addr == A_DIR);
  wire wr_asg = bus_wr && (bus_addr == A_ASG);
  wire unused_hi = ^bus_wdata[DW-1:W];

  always_ff @(posedge clk)
    if (wr_dat) lat_q <= bus_wdata[W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      dir_q <= '0;
    else if (wr_dir) dir_q <= bus_wdata[W-1:0];

  always_ff @(posedge clk)
    if (!rst_n)      asg_q <= {W{cfg_line}};
    else if (wr_asg) asg_q <= bus_wdata[W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
    end

  always_comb begin
    case (bus_addr)
      A_DAT0, A_DAT1: rd_val = (dir_q & lat_q) | (~dir_q & s2_q);
      A_DIR:          rd_val = dir_q;
      A_ASG:          rd_val = asg_q;
      default:        rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= {{PADW{1'b0}}, rd_val};

  assign pin_out = (asg_q & alt_out) | (~asg_q & lat_q);
  assign pin_oe  = (asg_q & alt_oe)  | (~asg_q & dir_q);
  assign alt_in  = s2_q;
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
  parameter int W  = 8,
  parameter int AW = 3,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_line,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic [W-1:0]  pin_out,
  input logic [W-1:0]  pin_oe,
  input logic [W-1:0]  alt_oe,
  input logic [W-1:0]  asg_q
);
  AST_RDATA_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:W] == '0); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R8
  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == AW'(2) |=> ((pin_oe ^ $past(bus_wdata[W-1:0])) & ~asg_q) == '0); // R3
  AST_ALT_OE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == AW'(3) |=> ((pin_oe ^ alt_oe) & $past(bus_wdata[W-1:0])) == '0); // R4
  AST_DATA_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr[AW-1:1] == '0 |=> ((pin_out ^ $past(bus_wdata[W-1:0])) & ~asg_q) == '0); // R1
  AST_CFG_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> asg_q == {W{$past(cfg_line)}}); // R5
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.W(W), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_line(cfg_line), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .alt_oe(alt_oe), .asg_q(asg_q)
);

// File: tb/gpio_mux_port_test.sv
`timescale 1ns/100ps
module gpio_mux_port_test;
  logic clk = 0, rst_n = 0, cfg_line = 1, bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic [7:0] pin_in = 8'hA5, pin_out, pin_oe, alt_out = 0, alt_oe = 0, alt_in;
  logic [7:0] m_lat, m_dir, m_asg;
  logic [15:0] got;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  gpio_mux_port uut (.clk(clk), .rst_n(rst_n), .cfg_line(cfg_line), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .alt_out(alt_out),
    .alt_oe(alt_oe), .alt_in(alt_in));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0, 3'd1: return {8'h00, (m_dir & m_lat) | (~m_dir & pin_in)};
      3'd2: return {8'h00, m_dir};
      3'd3: return {8'h00, m_asg};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [7:0] exp_out();
    return (m_asg & alt_out) | (~m_asg & m_lat);
  endfunction

  function automatic logic [7:0] exp_oe();
    return (m_asg & alt_oe) | (~m_asg & m_dir);
  endfunction

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    case (a)
      3'd0, 3'd1: m_lat = d[7:0];
      3'd2: m_dir = d[7:0];
      3'd3: m_asg = d[7:0];
      default: ;
    endcase
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(posedge clk);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic do_reset(logic cfg);
    @(negedge clk);
    rst_n = 0; cfg_line = cfg;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_dir = 8'h00; m_asg = {8{cfg}};
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_up();
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(1'b1);
    chk("R8 rdata reset", bus_rdata, 16'h0000);
    chk("R5 all alt oe", {8'h00, pin_oe}, {8'h00, alt_oe});
    rd(3'd3, got); chk("R5 asg=cfg 1", got, 16'h00FF);
    rd(3'd2, got); chk("R3 dir reset", got, 16'h0000);
    rd(3'd0, got); chk("R2 input read", got, 16'h00A5);

    wr(3'd1, 16'hFF3C);
    wr(3'd3, 16'h770F);
    wr(3'd2, 16'h00F0);
    alt_out = 8'h0A; alt_oe = 8'h03;
    #1;
    chk("R4 pin_out mux", {8'h00, pin_out}, 16'h003A);
    chk("R4 pin_oe mux", {8'h00, pin_oe}, 16'h00F3);
    rd(3'd0, got); chk("R1 alias read 0", got, 16'h0035);
    rd(3'd1, got); chk("R1 alias read 1", got, 16'h0035);
    rd(3'd3, got); chk("R9 asg readback", got, 16'h000F);
    rd(3'd2, got); chk("R9 dir readback", got, 16'h00F0);
    wr(3'd2, 16'h0011);
    chk("R8 rdata hold", bus_rdata, 16'h00F0);
    wr(3'd5, 16'hFFFF);
    rd(3'd5, got); chk("R6 unmapped read", got, 16'h0000);
    rd(3'd2, got); chk("R6 unmapped write", got, 16'h0011);

    @(negedge clk); pin_in = 8'h5A;
    @(posedge clk); #1 chk("R7 one edge old", {8'h00, alt_in}, 16'h00A5);
    @(posedge clk); #1 chk("R7 two edges new", {8'h00, alt_in}, 16'h005A);

    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 3);
      if (op == 0) wr(3'($urandom_range(0, 7)), 16'($urandom));
      else if (op == 1) begin
        logic [2:0] a = 3'($urandom_range(0, 7));
        rd(a, got); chk($sformatf("R2 R6 R9 rand read a=%0d", a), got, exp_rd(a));
      end else if (op == 2) begin
        @(negedge clk); pin_in = 8'($urandom);
        repeat (3) @(negedge clk);
        chk("R7 alt_in", {8'h00, alt_in}, {8'h00, pin_in});
      end else begin
        @(negedge clk); alt_out = 8'($urandom); alt_oe = 8'($urandom);
        #1;
        chk("R4 rand pin_out", {8'h00, pin_out}, {8'h00, exp_out()});
        chk("R4 rand pin_oe", {8'h00, pin_oe}, {8'h00, exp_oe()});
      end
    end

    wr(3'd0, 16'h00C3);
    do_reset(1'b0);
    chk("R8 rdata reset 2", bus_rdata, 16'h0000);
    rd(3'd3, got); chk("R5 asg=cfg 0", got, 16'h0000);
    #1 chk("R1 latch kept", {8'h00, pin_out}, 16'h00C3);
    chk("R3 oe cleared", {8'h00, pin_oe}, 16'h0000);
    finish_up();
  end
endmodule